// File: doc/BRIEF.md
# Circular Pointer Corrector

This block applies circular-buffer correction to a pointer update in an address generator. Each cycle it may take one request with the current pointer value, a signed byte offset, an addressing-mode code and the number of the pointer register in use. It returns the effective address for the memory access and, for the modes that modify the pointer, the corrected value to write back to that register. The result is registered and appears one cycle after the request.

The buffer is set up through a small register set: an enable bit with a pointer-select field, a start address and an end address. Correction applies only when the request names the selected pointer. The boundary test runs in one direction only. An upward update is folded back when it passes the end, and a downward update is folded forward when it drops below the start. An overshoot of up to one buffer length keeps its circular offset. A chip holds two instances, one for each data space.

Top module: `modring_ptr_fix`

## Requirements
- R1: The low bit written to the start register (cfg_addr 1) is ignored and taken as 0. The low bit written to the end register (cfg_addr 2) is ignored and taken as 1. The buffer length is end minus start plus 1 bytes.
- R2: Correction is applied only when the enable bit (bit 0 of the control word at cfg_addr 0) is 1, the selected pointer (bits 4:1 of that word) is not 15, and req_reg equals the selected pointer. Otherwise the raw sum req_ptr plus req_off is used unchanged.
- R3: For the upward modes (req_mode 0 post-increment, 2 pre-increment), a raw sum greater than the end address is reduced by the buffer length.
- R4: For the downward modes (req_mode 1 post-decrement, 3 pre-decrement), a raw sum smaller than the start address is increased by the buffer length. A sum equal to the start is kept.
- R5: In post modes (0, 1) out_ea equals req_ptr. In pre modes (2, 3) out_ea equals the corrected address. In all four modes out_wb carries the corrected address and out_wb_en is 1.
- R6: In register-indexed mode (4) and literal-offset mode (5), out_ea is the corrected sum, out_wb_en is 0 and out_wb equals req_ptr. The sign of req_off sets the direction of the test.
- R7: A raw sum that passes the boundary by up to one buffer length is folded back inside the buffer with its circular offset kept.
- R8: A configuration write takes effect from the next cycle. A request in the same cycle as the write uses the previous configuration.
- R9: out_valid is 1 exactly one cycle after each request and 0 otherwise. Reset clears out_valid, out_ea, out_wb and out_wb_en, disables correction and selects pointer 15.
- R10: A corrected pointer update that stays inside the buffer passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 start, 2 end |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_ptr | input | ADDR_W | Current pointer value |
| req_off | input | OFF_W | Signed byte offset |
| req_mode | input | 3 | Addressing-mode code |
| req_reg | input | PSEL_W | Number of the pointer register used |
| out_valid | output | 1 | Result valid |
| out_ea | output | ADDR_W | Effective address |
| out_wb | output | ADDR_W | Pointer write-back value |
| out_wb_en | output | 1 | Write-back required |

## Verification
The in-range assertion assumes three things about the inputs. A corrected request starts from a pointer inside the configured buffer. Its offset is no larger than one buffer length. Start is not above end. The stimulus keeps every request on the selected pointer within those bounds. It also changes configuration only between requests or in the same-cycle case that exercises the timing of a write. The pass-through and write-back checks assume nothing about the inputs.

// File: rtl/mr_pkg.sv
// Shared types for the circular pointer corrector.
// Assumes mode codes are three bits wide; codes 6 and 7 behave as offset modes.
package mr_pkg;

    typedef enum logic [2:0] {
        MD_POST_INC = 3'd0,
        MD_POST_DEC = 3'd1,
        MD_PRE_INC  = 3'd2,
        MD_PRE_DEC  = 3'd3,
        MD_REG_IDX  = 3'd4,
        MD_LIT_OFF  = 3'd5
    } ptr_mode_e;

    typedef enum logic [1:0] {
        CA_CTRL  = 2'd0,
        CA_START = 2'd1,
        CA_END   = 2'd2
    } cfg_addr_e;

    // True for the four modes that write the pointer back
    function automatic logic md_modifies(ptr_mode_e m);
        return (m == MD_POST_INC) || (m == MD_POST_DEC) ||
               (m == MD_PRE_INC)  || (m == MD_PRE_DEC);
    endfunction

    // True for modes that move the pointer upward
    function automatic logic md_upward(ptr_mode_e m);
        return (m == MD_POST_INC) || (m == MD_PRE_INC);
    endfunction

    // True for modes whose effective address is the old pointer
    function automatic logic md_post(ptr_mode_e m);
        return (m == MD_POST_INC) || (m == MD_POST_DEC);
    endfunction

endpackage

// File: rtl/mr_cfg_bank.sv
// Configuration register set of the corrector: enable, pointer select and
// buffer bounds. Start low bit is forced to 0, end low bit forced to 1.
// Assumes ADDR_W > PSEL_W so the control word holds enable and select.
module mr_cfg_bank
    import mr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              ring_on,
    output logic [PSEL_W-1:0] ring_sel,
    output logic [ADDR_W-1:0] ring_lo,
    output logic [ADDR_W-1:0] ring_hi
);

    // Register writes; the new value is seen by requests from the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_on  <= 1'b0;
            ring_sel <= '1;
            ring_lo  <= '0;
            ring_hi  <= {{(ADDR_W-1){1'b0}}, 1'b1};
        end else if (wr_en) begin
            case (cfg_addr_e'(wr_addr))
                CA_CTRL: begin
                    ring_on  <= wr_data[0];
                    ring_sel <= wr_data[PSEL_W:1];
                end
                CA_START: ring_lo <= {wr_data[ADDR_W-1:1], 1'b0};
                CA_END:   ring_hi <= {wr_data[ADDR_W-1:1], 1'b1};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mr_ring_fold.sv
// One-directional boundary fold. Upward: above end -> subtract length.
// Downward: below start -> add length. Assumes overshoot <= one length.
module mr_ring_fold #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic              count_up,
    input  logic              fold_en,
    input  logic [ADDR_W-1:0] ring_lo,
    input  logic [ADDR_W-1:0] ring_hi,
    output logic [ADDR_W-1:0] fold_addr
);

    logic [ADDR_W-1:0] span;
    logic              past_hi;
    logic              past_lo;

    // Buffer length in bytes and the two boundary tests
    always_comb begin
        span    = ring_hi - ring_lo + ADDR_W'(1);
        past_hi = raw_addr > ring_hi;
        past_lo = raw_addr < ring_lo;
    end

    // Select the folded or raw address for the active direction
    always_comb begin
        fold_addr = raw_addr;
        if (fold_en) begin
            if (count_up && past_hi)
                fold_addr = raw_addr - span;
            else if (!count_up && past_lo)
                fold_addr = raw_addr + span;
        end
    end

endmodule

// File: rtl/modring_ptr_fix.sv
// Circular pointer corrector top. Forms the raw pointer sum, folds it into
// the configured buffer when the request uses the selected pointer, and
// registers effective address and write-back one cycle later.
// Assumes requests on the selected pointer start inside the buffer.
module modring_ptr_fix
    import mr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 11,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_ptr,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [2:0]        req_mode,
    input  logic [PSEL_W-1:0] req_reg,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_ea,
    output logic [ADDR_W-1:0] out_wb,
    output logic              out_wb_en
);

    localparam logic [PSEL_W-1:0] STACK_SEL = '1;

    logic              ring_on;
    logic [PSEL_W-1:0] ring_sel;
    logic [ADDR_W-1:0] ring_lo;
    logic [ADDR_W-1:0] ring_hi;

    ptr_mode_e         mode;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] raw_sum;
    logic              modify;
    logic              dir_up;
    logic              hit;
    logic [ADDR_W-1:0] fixed;
    logic [ADDR_W-1:0] ea_n;
    logic [ADDR_W-1:0] wb_n;
    logic [ADDR_W-1:0] fixed_q;

    mr_cfg_bank #(.ADDR_W(ADDR_W), .PSEL_W(PSEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .ring_on  (ring_on),
        .ring_sel (ring_sel),
        .ring_lo  (ring_lo),
        .ring_hi  (ring_hi)
    );

    // Decode the request: raw sum, direction and whether correction applies
    always_comb begin
        mode    = ptr_mode_e'(req_mode);
        off_ext = {{(ADDR_W-OFF_W){req_off[OFF_W-1]}}, req_off};
        raw_sum = req_ptr + off_ext;
        modify  = md_modifies(mode);
        dir_up  = modify ? md_upward(mode) : !req_off[OFF_W-1];
        hit     = ring_on && (ring_sel != STACK_SEL) && (req_reg == ring_sel);
    end

    mr_ring_fold #(.ADDR_W(ADDR_W)) u_fold (
        .raw_addr  (raw_sum),
        .count_up  (dir_up),
        .fold_en   (hit),
        .ring_lo   (ring_lo),
        .ring_hi   (ring_hi),
        .fold_addr (fixed)
    );

    // Route the folded address to the effective address and write-back
    always_comb begin
        ea_n = md_post(mode) ? req_ptr : fixed;
        wb_n = modify ? fixed : req_ptr;
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ea    <= '0;
            out_wb    <= '0;
            out_wb_en <= 1'b0;
            fixed_q   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_ea    <= ea_n;
                out_wb    <= wb_n;
                out_wb_en <= modify;
                fixed_q   <= fixed;
            end else begin
                out_wb_en <= 1'b0;
            end
        end
    end

    assert_valid_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    assert_no_wb_offset_modes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !modify) |=> !out_wb_en);

    assert_fold_inside_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit) |=>
            (fixed_q >= $past(ring_lo)) && (fixed_q <= $past(ring_hi)));

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit && modify) |=> (out_wb == $past(req_ptr + off_ext)));

endmodule

// File: tb/tb_modring_ptr_fix.sv
module tb_modring_ptr_fix;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_ptr = '0;
    logic [10:0] req_off = '0;
    logic [2:0]  req_mode = '0;
    logic [3:0]  req_reg = '0;
    logic        out_valid;
    logic [15:0] out_ea;
    logic [15:0] out_wb;
    logic        out_wb_en;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [15:0] q_ea[$];
    logic [15:0] q_wb[$];
    logic        q_wbe[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    modring_ptr_fix dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ptr(req_ptr), .req_off(req_off),
        .req_mode(req_mode), .req_reg(req_reg),
        .out_valid(out_valid), .out_ea(out_ea), .out_wb(out_wb),
        .out_wb_en(out_wb_en)
    );

    task automatic put_req(input logic [15:0] p, input logic signed [10:0] o,
                           input logic [2:0] m, input logic [3:0] r,
                           input logic [15:0] e_ea, input logic [15:0] e_wb,
                           input logic e_wbe, input string tag);
        req_valid = 1'b1;
        req_ptr   = p;
        req_off   = o;
        req_mode  = m;
        req_reg   = r;
        q_ea.push_back(e_ea);
        q_wb.push_back(e_wb);
        q_wbe.push_back(e_wbe);
        q_tag.push_back(tag);
    endtask

    task automatic issue(input logic [15:0] p, input logic signed [10:0] o,
                         input logic [2:0] m, input logic [3:0] r,
                         input logic [15:0] e_ea, input logic [15:0] e_wb,
                         input logic e_wbe, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        put_req(p, o, m, r, e_ea, e_wb, e_wbe, tag);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    // Monitor: pops expected results as the design presents them
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            tests++;
            if (q_ea.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected result actual ea=%h expected none", out_ea);
            end else begin
                logic [15:0] e_ea;
                logic [15:0] e_wb;
                logic        e_wbe;
                string       tg;
                e_ea  = q_ea.pop_front();
                e_wb  = q_wb.pop_front();
                e_wbe = q_wbe.pop_front();
                tg    = q_tag.pop_front();
                if (out_ea !== e_ea || out_wb !== e_wb || out_wb_en !== e_wbe) begin
                    fails++;
                    $display("FAIL %s actual ea=%h wb=%h wbe=%b expected ea=%h wb=%h wbe=%b",
                             tg, out_ea, out_wb, out_wb_en, e_ea, e_wb, e_wbe);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || out_wb_en !== 1'b0 || out_ea !== 16'h0 || out_wb !== 16'h0) begin
            fails++;
            $display("FAIL R9 reset actual v=%b wbe=%b ea=%h wb=%h expected 0 0 0000 0000",
                     out_valid, out_wb_en, out_ea, out_wb);
        end
        rst_n = 1'b1;

        issue(16'h1162, 11'sd2, 3'd0, 4'd1, 16'h1162, 16'h1164, 1'b1, "R2 disabled after reset");
        cfg_write(2'd1, 16'h1101);
        cfg_write(2'd2, 16'h1162);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0003;
        put_req(16'h1162, 11'sd2, 3'd0, 4'd1, 16'h1162, 16'h1164, 1'b1, "R8 same-cycle old config");
        issue(16'h1162, 11'sd2, 3'd0, 4'd1, 16'h1162, 16'h1100, 1'b1, "R8 R3 R1 wrap at end");
        issue(16'h1100, 11'sd2, 3'd0, 4'd1, 16'h1100, 16'h1102, 1'b1, "R10 inside buffer");
        issue(16'h1162, 11'sd2, 3'd2, 4'd1, 16'h1100, 16'h1100, 1'b1, "R5 pre-increment");
        issue(16'h1163, 11'sd1, 3'd2, 4'd1, 16'h1100, 16'h1100, 1'b1, "R3 byte step");
        issue(16'h1160, 11'sd100, 3'd0, 4'd1, 16'h1160, 16'h1160, 1'b1, "R7 overshoot up");
        issue(16'h1100, -11'sd2, 3'd1, 4'd1, 16'h1100, 16'h1162, 1'b1, "R4 post-decrement wrap");
        issue(16'h1102, -11'sd2, 3'd3, 4'd1, 16'h1100, 16'h1100, 1'b1, "R4 equal start kept");
        issue(16'h1100, -11'sd100, 3'd3, 4'd1, 16'h1100, 16'h1100, 1'b1, "R7 overshoot down");
        issue(16'h1162, 11'sd2, 3'd0, 4'd2, 16'h1162, 16'h1164, 1'b1, "R2 other pointer");
        issue(16'h1160, 11'sd6, 3'd4, 4'd1, 16'h1102, 16'h1160, 1'b0, "R6 register-indexed");
        issue(16'h1104, -11'sd8, 3'd5, 4'd1, 16'h1160, 16'h1104, 1'b0, "R6 literal-offset");
        cfg_write(2'd0, 16'h001F);
        issue(16'h1162, 11'sd2, 3'd0, 4'd15, 16'h1162, 16'h1164, 1'b1, "R2 stack pointer");
        cfg_write(2'd0, 16'h0002);
        issue(16'h1162, 11'sd2, 3'd0, 4'd1, 16'h1162, 16'h1164, 1'b1, "R2 enable cleared");
        idle();
        repeat (3) @(negedge clk);

        tests++;
        if (q_ea.size() != 0 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 pending actual %0d v=%b expected 0 0", q_ea.size(), out_valid);
        end
        finish_run();
    end

endmodule